// File: doc/BRIEF.md
# Secondary Safe Channel Status Validator

This block checks the status byte that comes with every position record on the secondary safe channel of a motor feedback link. It keeps track of the toggle value it expects next and flags any record whose toggle bit repeats the previous one. It compares the five low status bits against a fixed signature. It decodes the position-error and test-performed bits and merges them into a summary. It also takes a CRC-ok indication from an external checker. These results are combined into one channel-invalid flag for the position that came with the record.

Every flag is a live status that describes the most recent record. All flags are loaded together on each valid strobe and hold their values between strobes. A protocol-reset input clears every flag and returns the toggle expectation to 0. The first record after a reset or a protocol reset must therefore carry toggle 0. After a toggle fault, the tracker takes the received toggle as its new reference, so a single bad record does not cause faults on the records that follow.

Top module: `sc2_status_validator`

## Requirements
- R1: After the asynchronous reset is released, all outputs are 0 and the first expected toggle value is 0.
- R2: A record whose toggle bit (bit 7) differs from the expected value sets `toggle_fault`. The first record after reset with toggle 1 is such a record.
- R3: Records whose toggle bits alternate 0,1,0,1,... starting from 0 produce no `toggle_fault`.
- R4: After a faulted record, the received toggle becomes the reference: the next record is expected to carry the inverse of the faulted record's toggle bit.
- R5: `pattern_fault` is 1 exactly when status bits 4:0 of the last record differ from 5'b11100.
- R6: `pos_error` mirrors bit 5 and `test_done` mirrors bit 6 of the last record; `summary` is their OR.
- R7: `crc_fault` is 1 exactly when `crc_ok` was 0 with the last record.
- R8: `chan_invalid` is the OR of toggle fault, pattern fault, position error and CRC fault for the last record; the test bit alone does not set it.
- R9: All outputs change only in the cycle after a valid strobe or a protocol reset, and otherwise hold.
- R10: A protocol reset clears all outputs on the next cycle and resets the expected toggle to 0. It takes priority over a strobe in the same cycle, and that record is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_vld | input | 1 | Status byte strobe, one cycle per record |
| stat_byte | input | 8 | Status byte: 7 toggle, 6 test, 5 error, 4:0 signature |
| crc_ok | input | 1 | CRC of this record was correct (sampled with stat_vld) |
| proto_rst | input | 1 | Protocol reset, clears flags and toggle expectation |
| pos_error | output | 1 | Position-error bit of last record |
| test_done | output | 1 | Test-performed bit of last record |
| summary | output | 1 | OR of pos_error and test_done |
| toggle_fault | output | 1 | Last record repeated the previous toggle |
| pattern_fault | output | 1 | Signature bits of last record were wrong |
| crc_fault | output | 1 | Last record failed its CRC |
| chan_invalid | output | 1 | Position of last record must not be used |

## Verification
The bench applies every status byte value with both CRC outcomes. A reference model tracks the toggle expectation, so a tracker that does not resynchronise after a fault would report a fault on every record after the first one. The sweep pulses protocol resets at points with odd and even toggle phase, which catches an expectation that is not returned to 0. It also drives one reset together with a strobe, which catches a design that lets the record through. Idle stretches with a changing status byte expose flags that follow the input without the strobe. Records with only the test bit set show whether the test bit wrongly invalidates the position.

// File: rtl/sc2_status_pkg.sv
package sc2_status_pkg;

  // Live flag set produced for every accepted record
  typedef struct packed {
    logic pos_error;
    logic test_done;
    logic summary;
    logic toggle_fault;
    logic pattern_fault;
    logic crc_fault;
    logic chan_invalid;
  } sc2_flags_t;

  localparam sc2_flags_t SC2_FLAGS_CLR = '0;

endpackage

// File: rtl/sc2_toggle_tracker.sv
module sc2_toggle_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic clr,
  input  logic tog_in,
  output logic fault_nxt
);

  logic expect_q;
  logic expect_d;

  // Compare only for an accepted record
  always_comb begin
    fault_nxt = strobe && !clr && (tog_in != expect_q);
  end

  // Reference follows the received bit, so a fault resynchronises
  always_comb begin
    expect_d = expect_q;
    if (clr) begin
      expect_d = 1'b0;
    end else if (strobe) begin
      expect_d = ~tog_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= 1'b0;
    end else begin
      expect_q <= expect_d;
    end
  end

endmodule

// File: rtl/sc2_signature_check.sv
module sc2_signature_check #(
  parameter int          SIG_W   = 5,
  parameter logic [SIG_W-1:0] SIG_VAL = 5'b11100
) (
  input  logic [SIG_W-1:0] sig_in,
  output logic             mismatch
);

  logic [SIG_W-1:0] bit_bad;

  for (genvar i = 0; i < SIG_W; i++) begin : g_bit
    assign bit_bad[i] = sig_in[i] ^ SIG_VAL[i];
  end

  assign mismatch = |bit_bad;

endmodule

// File: rtl/sc2_flag_register.sv
module sc2_flag_register
  import sc2_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       clr,
  input  sc2_flags_t flags_in,
  output sc2_flags_t flags_q
);

  sc2_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr) begin
      flags_d = SC2_FLAGS_CLR;
    end else if (load) begin
      flags_d = flags_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= SC2_FLAGS_CLR;
    end else begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/sc2_status_validator.sv
module sc2_status_validator
  import sc2_status_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int TOG_BIT  = 7,
  parameter int TEST_BIT = 6,
  parameter int ERR_BIT  = 5,
  parameter int SIG_W    = 5,
  parameter logic [SIG_W-1:0] SIG_VAL = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_vld,
  input  logic [STAT_W-1:0] stat_byte,
  input  logic              crc_ok,
  input  logic              proto_rst,
  output logic              pos_error,
  output logic              test_done,
  output logic              summary,
  output logic              toggle_fault,
  output logic              pattern_fault,
  output logic              crc_fault,
  output logic              chan_invalid
);

  localparam int SIG_LSB = 0;
  localparam int SIG_MSB = SIG_LSB + SIG_W - 1;

  logic       tog_fault_nxt;
  logic       sig_bad;
  sc2_flags_t flags_nxt;
  sc2_flags_t flags_q;

  sc2_toggle_tracker u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (stat_vld),
    .clr       (proto_rst),
    .tog_in    (stat_byte[TOG_BIT]),
    .fault_nxt (tog_fault_nxt)
  );

  sc2_signature_check #(
    .SIG_W   (SIG_W),
    .SIG_VAL (SIG_VAL)
  ) u_sig (
    .sig_in   (stat_byte[SIG_MSB:SIG_LSB]),
    .mismatch (sig_bad)
  );

  // Decode and merge the record into the next flag set
  always_comb begin
    flags_nxt               = SC2_FLAGS_CLR;
    flags_nxt.pos_error     = stat_byte[ERR_BIT];
    flags_nxt.test_done     = stat_byte[TEST_BIT];
    flags_nxt.summary       = stat_byte[ERR_BIT] | stat_byte[TEST_BIT];
    flags_nxt.toggle_fault  = tog_fault_nxt;
    flags_nxt.pattern_fault = sig_bad;
    flags_nxt.crc_fault     = ~crc_ok;
    flags_nxt.chan_invalid  = tog_fault_nxt | sig_bad | stat_byte[ERR_BIT] | ~crc_ok;
  end

  sc2_flag_register u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stat_vld),
    .clr      (proto_rst),
    .flags_in (flags_nxt),
    .flags_q  (flags_q)
  );

  assign pos_error     = flags_q.pos_error;
  assign test_done     = flags_q.test_done;
  assign summary       = flags_q.summary;
  assign toggle_fault  = flags_q.toggle_fault;
  assign pattern_fault = flags_q.pattern_fault;
  assign crc_fault     = flags_q.crc_fault;
  assign chan_invalid  = flags_q.chan_invalid;

endmodule

// File: rtl/sc2_status_validator_sva.sv
module sc2_status_validator_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_vld,
  input logic [7:0] stat_byte,
  input logic       crc_ok,
  input logic       proto_rst,
  input logic       pos_error,
  input logic       test_done,
  input logic       summary,
  input logic       toggle_fault,
  input logic       pattern_fault,
  input logic       crc_fault,
  input logic       chan_invalid
);

  logic [6:0] outs;
  assign outs = {pos_error, test_done, summary, toggle_fault, pattern_fault, crc_fault, chan_invalid};

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_vld && !proto_rst) |=> $stable(outs));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_rst |=> (outs == 7'd0));

  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    summary == (pos_error | test_done));

  assert_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_invalid == (toggle_fault | pattern_fault | pos_error | crc_fault));

  assert_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !proto_rst && (stat_byte[4:0] != 5'b11100)) |=> pattern_fault);

  assert_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !proto_rst) |=> (crc_fault == !$past(crc_ok)));

endmodule

bind sc2_status_validator sc2_status_validator_sva u_sva (.*);

// File: tb/sc2_status_validator_bench.sv
module sc2_status_validator_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_vld = 1'b0;
  logic [7:0] stat_byte = 8'h00;
  logic       crc_ok = 1'b1;
  logic       proto_rst = 1'b0;
  logic       pos_error, test_done, summary, toggle_fault, pattern_fault, crc_fault, chan_invalid;

  int  n_vec = 0;
  int  n_bad = 0;
  logic exp_tog = 1'b0;
  logic [6:0] last_exp = 7'd0;

  always #10 clk = ~clk;

  sc2_status_validator u_sc2_status_validator (
    .clk, .rst_n, .stat_vld, .stat_byte, .crc_ok, .proto_rst,
    .pos_error, .test_done, .summary, .toggle_fault, .pattern_fault,
    .crc_fault, .chan_invalid
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_all(input logic [6:0] e, input string treq);
    chk("R6 pos_error", pos_error, e[6]);
    chk("R6 test_done", test_done, e[5]);
    chk("R6 summary", summary, e[4]);
    chk(treq, toggle_fault, e[3]);
    chk("R5 pattern_fault", pattern_fault, e[2]);
    chk("R7 crc_fault", crc_fault, e[1]);
    chk("R8 chan_invalid", chan_invalid, e[0]);
  endtask

  // Apply one record and check at the following falling edge
  task automatic apply(input logic [7:0] b, input logic ok);
    logic tf, pf;
    string treq;
    treq = (exp_tog == 1'b0 && b[7]) ? "R2 toggle_fault" : (tf_prev_fault ? "R4 toggle_fault" : "R3 toggle_fault");
    stat_byte = b;
    crc_ok    = ok;
    stat_vld  = 1'b1;
    @(negedge clk);
    stat_vld  = 1'b0;
    tf = (b[7] != exp_tog);
    pf = (b[4:0] != 5'b11100);
    exp_tog = ~b[7];
    tf_prev_fault = tf;
    last_exp = {b[5], b[6], b[5] | b[6], tf, pf, ~ok, tf | pf | b[5] | ~ok};
    chk_all(last_exp, treq);
  endtask

  logic tf_prev_fault = 1'b0;

  task automatic prst(input logic with_strobe, input logic [7:0] b);
    proto_rst = 1'b1;
    stat_vld  = with_strobe;
    stat_byte = b;
    crc_ok    = 1'b0;
    @(negedge clk);
    proto_rst = 1'b0;
    stat_vld  = 1'b0;
    crc_ok    = 1'b1;
    exp_tog   = 1'b0;
    tf_prev_fault = 1'b0;
    last_exp  = 7'd0;
    chk_all(7'd0, "R10 toggle_fault");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_all(7'd0, "R1 toggle_fault");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(7'd0, "R1 toggle_fault");

    // R3: clean alternating sequence starting at 0
    for (int i = 0; i < 6; i++) begin
      apply({i[0], 2'b00, 5'b11100}, 1'b1);
    end
    // R4: repeat a toggle, then resync on the inverse
    apply(8'h1C, 1'b1);
    apply(8'h1C, 1'b1);
    apply(8'h9C, 1'b1);
    // R8: test bit alone leaves the position valid
    apply(8'h5C, 1'b1);
    chk("R8 test only valid", chan_invalid, 1'b0);

    // R10: protocol reset with a concurrent strobe, record discarded
    prst(1'b1, 8'h80);
    apply(8'h1C, 1'b1);
    chk("R10 expect toggle 0", toggle_fault, 1'b0);

    // R2: first record after protocol reset with toggle 1
    prst(1'b0, 8'h00);
    apply(8'h9C, 1'b1);
    chk("R2 first toggle 1", toggle_fault, 1'b1);

    // Near-exhaustive sweep: all bytes, both CRC outcomes, resets sprinkled
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 256; b++) begin
        apply(b[7:0], r[0] ^ b[3]);
        if ((b % 37) == 36) prst(b[0], b[7:0]);
        if ((b % 29) == 5) begin
          // R9: idle with changing input, flags must hold
          for (int k = 0; k < 3; k++) begin
            stat_byte = ~stat_byte;
            crc_ok    = ~crc_ok;
            @(negedge clk);
            chk_all(last_exp, "R9 toggle_fault");
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule